// File: doc/BRIEF.md
# Unmasked Count Shift and Rotate Unit

This unit performs the eight shift and rotate operations of an early 16-bit processor on byte or word operands. Unlike later processors, it never trims the shift count to five bits. Every bit of the 8-bit count takes part.

Rotates fold the count back into a range that begins at 1, using the length of the rotate loop. Shifts stop at 17, which is enough to push every operand bit out.

The unit takes the following inputs:
- the operand
- a width select
- a 3-bit operation code
- the count, from an immediate byte or from the low byte of the count register
- the incoming flags

It returns the result, the updated flags and the number of cycles the operation costs. All outputs are registered on a valid strobe. Fetching operands, computing addresses and writing results back to memory belong to the surrounding core.

Top module: `unmasked_shifter`

## Requirements
- R1: While reset is asserted, out_result, all five flag outputs, out_cycles and out_valid are zero.
- R2: in_op selects the operation as follows. 0 is rotate left (ROL), 1 is rotate right (ROR), 2 is rotate left through carry (RCL), 3 is rotate right through carry (RCR), 4 is shift left (SHL), 5 is logical shift right (SHR), 6 behaves exactly like 4, and 7 is arithmetic shift right (SAR).
- R3: For ROL and ROR at either width, a raw count of 0 stays 0, and any other raw count n acts as ((n-1) mod 16)+1. For ROL, CF ends equal to the result's bit 0. For ROR, CF ends equal to the result's top bit.
- R4: For RCL and RCR, the carry flag is part of the rotated loop. A raw count of 0 stays 0. Any other raw count n acts as ((n-1) mod 9)+1 on bytes and as ((n-1) mod 17)+1 on words.
- R5: For SHL, SHR and SAR, raw counts 0..16 are used as given, and any count of 17 or more acts as 17. CF is the last bit shifted out. Logical shifts then give 0, and SAR gives copies of the sign bit.
- R6: When in_imm_sel is 1 the count is in_imm, otherwise it is in_creg. All 8 bits are used without masking.
- R7: out_cycles is 5 plus the raw count when in_mem is 0, and 8 plus the raw count when in_mem is 1.
- R8: With a nonzero effective count, rotates change only CF and OF. SF, ZF and PF are copied from the inputs.
- R9: With a nonzero effective count, shifts set the following flags. SF is the result's top bit. ZF is 1 when the result is 0. PF is 1 when the low result byte holds an even number of ones.
- R10: OF depends on the direction of the operation. For left operations (ROL, RCL, SHL), OF is the result's top bit XOR the new CF. For right operations (ROR, RCR, SHR, SAR), OF is the XOR of the two top result bits.
- R11: An effective count of zero returns the operand unchanged and copies all five input flags to the outputs.
- R12: Outputs load on the clock edge where in_valid is 1. out_valid is high for the following cycle only. Outputs are held while in_valid is 0.
- R13: With in_wide 0, only in_data[7:0] is used, and out_result[15:8] is 0. With in_wide 1, the whole 16-bit word is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_wide | input | 1 | 1 = word operand, 0 = byte operand |
| in_op | input | 3 | Operation code |
| in_imm_sel | input | 1 | 1 = count from in_imm, 0 = from in_creg |
| in_imm | input | 8 | Immediate count byte |
| in_creg | input | 8 | Low byte of the count register |
| in_mem | input | 1 | 1 = operand comes from memory (affects cost only) |
| in_data | input | 16 | Operand |
| in_cf | input | 1 | Incoming carry flag |
| in_of | input | 1 | Incoming overflow flag |
| in_sf | input | 1 | Incoming sign flag |
| in_zf | input | 1 | Incoming zero flag |
| in_pf | input | 1 | Incoming parity flag |
| out_valid | output | 1 | One-cycle pulse after a strobe |
| out_result | output | 16 | Result |
| out_cf | output | 1 | Carry flag |
| out_of | output | 1 | Overflow flag |
| out_sf | output | 1 | Sign flag |
| out_zf | output | 1 | Zero flag |
| out_pf | output | 1 | Parity flag |
| out_cycles | output | 9 | Cycle cost of the operation |

## Verification
The result, every flag and the cycle cost each pass through one register. All of them therefore appear on the first rising edge after the strobe, and out_valid is high for exactly that one cycle.

The bench sets up inputs on a falling edge, lets one rising edge pass, and reads every output at the next falling edge, which lies half a period after the load. To check holding, the bench then changes the inputs without a strobe and reads the outputs again two edges later.

// File: rtl/sru_pkg.sv
package sru_pkg;

   typedef enum logic [2:0] {
      OP_ROL = 3'd0,
      OP_ROR = 3'd1,
      OP_RCL = 3'd2,
      OP_RCR = 3'd3,
      OP_SHL = 3'd4,
      OP_SHR = 3'd5,
      OP_SAL = 3'd6,
      OP_SAR = 3'd7
   } sru_op_e;

   typedef struct packed {
      logic cf;
      logic of;
      logic sf;
      logic zf;
      logic pf;
   } sru_flags_t;

   function automatic logic op_is_rotate(sru_op_e op);
      return ~op[2];
   endfunction

   function automatic logic op_is_left(sru_op_e op);
      return (op == OP_ROL) || (op == OP_RCL) || (op == OP_SHL) || (op == OP_SAL);
   endfunction

endpackage

// File: rtl/sru_count_norm.sv
module sru_count_norm
   import sru_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int NARROW = 8,
   parameter int WIDE   = 16,
   parameter int KW     = 5
) (
   input  sru_op_e          op,
   input  logic             wide,
   input  logic [CNT_W-1:0] raw,
   output logic [KW-1:0]    eff
);
   localparam int ROT_LEN = WIDE;
   localparam int RC_NAR  = NARROW + 1;
   localparam int RC_WID  = WIDE + 1;
   localparam int SAT     = WIDE + 1;

   logic [31:0] less_one;
   logic [31:0] rem_plain;
   logic [31:0] rem_carry;

   always_comb begin
      less_one  = 32'(raw) - 32'd1;
      rem_plain = less_one % 32'(ROT_LEN);
      rem_carry = wide ? (less_one % 32'(RC_WID)) : (less_one % 32'(RC_NAR));
      if (op_is_rotate(op)) begin
         if (raw == '0)
            eff = '0;
         else if (op == OP_RCL || op == OP_RCR)
            eff = KW'(rem_carry + 32'd1);
         else
            eff = KW'(rem_plain + 32'd1);
      end else begin
         if (32'(raw) >= 32'(SAT))
            eff = KW'(SAT);
         else
            eff = KW'(raw);
      end
   end

endmodule

// File: rtl/sru_lane.sv
module sru_lane
   import sru_pkg::*;
#(
   parameter int W     = 8,
   parameter int KW    = 5,
   parameter int STEPS = 17
) (
   input  sru_op_e      op,
   input  logic [KW-1:0] k,
   input  logic [W-1:0] x,
   input  sru_flags_t   flags_in,
   output logic [W-1:0] res,
   output sru_flags_t   flags_out
);
   logic [W-1:0] v;
   logic         c;
   logic         nc;

   always_comb begin
      v  = x;
      c  = flags_in.cf;
      nc = 1'b0;
      for (int i = 0; i < STEPS; i++) begin
         if (i < int'(k)) begin
            case (op)
               OP_ROL: begin c = v[W-1]; v = {v[W-2:0], v[W-1]}; end
               OP_ROR: begin c = v[0];   v = {v[0], v[W-1:1]}; end
               OP_RCL: begin nc = v[W-1]; v = {v[W-2:0], c}; c = nc; end
               OP_RCR: begin nc = v[0];   v = {c, v[W-1:1]}; c = nc; end
               OP_SHL, OP_SAL: begin c = v[W-1]; v = {v[W-2:0], 1'b0}; end
               OP_SHR: begin c = v[0]; v = {1'b0, v[W-1:1]}; end
               default: begin c = v[0]; v = {v[W-1], v[W-1:1]}; end
            endcase
         end
      end

      flags_out = flags_in;
      res       = x;
      if (k != '0) begin
         res          = v;
         flags_out.cf = c;
         flags_out.of = op_is_left(op) ? (v[W-1] ^ c) : (v[W-1] ^ v[W-2]);
         if (!op_is_rotate(op)) begin
            flags_out.sf = v[W-1];
            flags_out.zf = (v == '0);
            flags_out.pf = ~^v[7:0];
         end
      end
   end

endmodule

// File: rtl/sru_cost.sv
module sru_cost #(
   parameter int CNT_W    = 8,
   parameter int CYC_W    = 9,
   parameter int REG_COST = 5,
   parameter int MEM_COST = 8
) (
   input  logic [CNT_W-1:0] raw,
   input  logic             mem,
   output logic [CYC_W-1:0] cycles
);
   localparam logic [CYC_W-1:0] REG_BASE = CYC_W'(REG_COST);
   localparam logic [CYC_W-1:0] MEM_BASE = CYC_W'(MEM_COST);

   assign cycles = CYC_W'(raw) + (mem ? MEM_BASE : REG_BASE);

endmodule

// File: rtl/unmasked_shifter.sv
module unmasked_shifter
   import sru_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 8,
   parameter int REG_COST = 5,
   parameter int MEM_COST = 8,
   localparam int CYC_W   = $clog2(MEM_COST + (1 << CNT_W))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_wide,
   input  logic [2:0]        in_op,
   input  logic              in_imm_sel,
   input  logic [CNT_W-1:0]  in_imm,
   input  logic [CNT_W-1:0]  in_creg,
   input  logic              in_mem,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_cf,
   input  logic              in_of,
   input  logic              in_sf,
   input  logic              in_zf,
   input  logic              in_pf,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_cf,
   output logic              out_of,
   output logic              out_sf,
   output logic              out_zf,
   output logic              out_pf,
   output logic [CYC_W-1:0]  out_cycles
);
   localparam int BYTE_W = DATA_W / 2;
   localparam int SAT    = DATA_W + 1;
   localparam int KW     = $clog2(SAT + 1);

   if (DATA_W != 16) begin : g_bad_width
      $error("unmasked_shifter: DATA_W must be 16");
   end
   if (CNT_W < 5) begin : g_bad_count
      $error("unmasked_shifter: CNT_W too narrow for saturation");
   end

   sru_op_e                op;
   logic [CNT_W-1:0]       raw_cnt;
   logic [KW-1:0]          eff_cnt;
   logic [CYC_W-1:0]       cost;
   sru_flags_t             flg_in;
   logic [DATA_W-1:0]      lane_res [2];
   sru_flags_t             lane_flg [2];

   assign op      = sru_op_e'(in_op);
   assign raw_cnt = in_imm_sel ? in_imm : in_creg;
   assign flg_in  = '{cf: in_cf, of: in_of, sf: in_sf, zf: in_zf, pf: in_pf};

   sru_count_norm #(
      .CNT_W (CNT_W),
      .NARROW(BYTE_W),
      .WIDE  (DATA_W),
      .KW    (KW)
   ) u_norm (
      .op  (op),
      .wide(in_wide),
      .raw (raw_cnt),
      .eff (eff_cnt)
   );

   sru_cost #(
      .CNT_W   (CNT_W),
      .CYC_W   (CYC_W),
      .REG_COST(REG_COST),
      .MEM_COST(MEM_COST)
   ) u_cost (
      .raw   (raw_cnt),
      .mem   (in_mem),
      .cycles(cost)
   );

   for (genvar g = 0; g < 2; g++) begin : g_lane
      localparam int LW = (g == 0) ? BYTE_W : DATA_W;
      logic [LW-1:0] r;
      sru_flags_t    f;
      sru_lane #(
         .W    (LW),
         .KW   (KW),
         .STEPS(SAT)
      ) u_lane (
         .op       (op),
         .k        (eff_cnt),
         .x        (in_data[LW-1:0]),
         .flags_in (flg_in),
         .res      (r),
         .flags_out(f)
      );
      assign lane_res[g] = DATA_W'(r);
      assign lane_flg[g] = f;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_cf     <= 1'b0;
         out_of     <= 1'b0;
         out_sf     <= 1'b0;
         out_zf     <= 1'b0;
         out_pf     <= 1'b0;
         out_cycles <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= lane_res[in_wide];
            out_cf     <= lane_flg[in_wide].cf;
            out_of     <= lane_flg[in_wide].of;
            out_sf     <= lane_flg[in_wide].sf;
            out_zf     <= lane_flg[in_wide].zf;
            out_pf     <= lane_flg[in_wide].pf;
            out_cycles <= cost;
         end
      end
   end

endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 8,
   parameter int REG_COST = 5,
   parameter int MEM_COST = 8,
   parameter int CYC_W    = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_wide,
   input logic [2:0]        in_op,
   input logic              in_imm_sel,
   input logic [CNT_W-1:0]  in_imm,
   input logic [CNT_W-1:0]  in_creg,
   input logic              in_mem,
   input logic [DATA_W-1:0] in_data,
   input logic              in_sf,
   input logic              in_zf,
   input logic              in_pf,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result,
   input logic              out_sf,
   input logic              out_zf,
   input logic              out_pf,
   input logic [CYC_W-1:0]  out_cycles
);
   localparam int HALF = DATA_W / 2;
   logic [CNT_W-1:0] chosen;
   logic             is_rot;
   logic             is_logic_shift;

   assign chosen         = in_imm_sel ? in_imm : in_creg;
   assign is_rot         = (in_op < 3'd4);
   assign is_logic_shift = (in_op == 3'd4) || (in_op == 3'd5) || (in_op == 3'd6);

   // R12
   strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R12
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_result) && $stable(out_cycles) && !out_valid));

   // R7
   reg_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_mem) |=> (out_cycles == CYC_W'($past(chosen)) + CYC_W'(REG_COST)));

   // R7
   mem_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mem) |=> (out_cycles == CYC_W'($past(chosen)) + CYC_W'(MEM_COST)));

   // R8
   rotate_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_rot) |=> (out_sf == $past(in_sf) && out_zf == $past(in_zf) && out_pf == $past(in_pf)));

   // R11
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && chosen == '0 && in_wide) |=> (out_result == $past(in_data)));

   // R13
   byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_wide) |=> (out_result[DATA_W-1:HALF] == '0));

   // R5
   shift_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_logic_shift && 32'(chosen) > DATA_W) |=> (out_result == '0 && out_zf));

endmodule

bind unmasked_shifter sru_checker #(
   .DATA_W  (DATA_W),
   .CNT_W   (CNT_W),
   .REG_COST(REG_COST),
   .MEM_COST(MEM_COST),
   .CYC_W   (CYC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_wide   (in_wide),
   .in_op     (in_op),
   .in_imm_sel(in_imm_sel),
   .in_imm    (in_imm),
   .in_creg   (in_creg),
   .in_mem    (in_mem),
   .in_data   (in_data),
   .in_sf     (in_sf),
   .in_zf     (in_zf),
   .in_pf     (in_pf),
   .out_valid (out_valid),
   .out_result(out_result),
   .out_sf    (out_sf),
   .out_zf    (out_zf),
   .out_pf    (out_pf),
   .out_cycles(out_cycles)
);

// File: tb/unmasked_shifter_bench.sv
`timescale 1ns/1ps
module unmasked_shifter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_wide = 1'b0;
   logic [2:0]  in_op = '0;
   logic        in_imm_sel = 1'b1;
   logic [7:0]  in_imm = '0;
   logic [7:0]  in_creg = '0;
   logic        in_mem = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_cf = 1'b0, in_of = 1'b0, in_sf = 1'b0, in_zf = 1'b0, in_pf = 1'b0;
   logic        out_valid;
   logic [15:0] out_result;
   logic        out_cf, out_of, out_sf, out_zf, out_pf;
   logic [8:0]  out_cycles;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   unmasked_shifter u_unmasked_shifter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide), .in_op(in_op),
      .in_imm_sel(in_imm_sel), .in_imm(in_imm), .in_creg(in_creg), .in_mem(in_mem),
      .in_data(in_data), .in_cf(in_cf), .in_of(in_of), .in_sf(in_sf), .in_zf(in_zf),
      .in_pf(in_pf), .out_valid(out_valid), .out_result(out_result), .out_cf(out_cf),
      .out_of(out_of), .out_sf(out_sf), .out_zf(out_zf), .out_pf(out_pf),
      .out_cycles(out_cycles)
   );

   typedef struct packed {
      logic        wide;
      logic [2:0]  op;
      logic [7:0]  cnt;
      logic [15:0] data;
      logic        cin;
      logic [15:0] res;
      logic        cf;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 3'd0, 8'd1,   16'hFF81, 1'b0, 16'h0003, 1'b1},  // R3 R13 ROL byte
      '{1'b0, 3'd0, 8'd17,  16'h0081, 1'b0, 16'h0003, 1'b1},  // R3 wrap 17->1
      '{1'b0, 3'd0, 8'd16,  16'h0081, 1'b0, 16'h0081, 1'b1},  // R3 16 kept
      '{1'b1, 3'd1, 8'd4,   16'h0001, 1'b0, 16'h1000, 1'b0},  // R3 ROR word
      '{1'b1, 3'd1, 8'd33,  16'h0001, 1'b0, 16'h8000, 1'b1},  // R3 wrap 33->1
      '{1'b0, 3'd2, 8'd1,   16'h0080, 1'b0, 16'h0000, 1'b1},  // R4 RCL byte
      '{1'b0, 3'd2, 8'd10,  16'h0080, 1'b0, 16'h0000, 1'b1},  // R4 mod 9
      '{1'b0, 3'd2, 8'd9,   16'h0055, 1'b1, 16'h0055, 1'b1},  // R4 full loop
      '{1'b1, 3'd3, 8'd18,  16'h0001, 1'b0, 16'h0000, 1'b1},  // R4 mod 17
      '{1'b1, 3'd3, 8'd17,  16'h1234, 1'b1, 16'h1234, 1'b1},  // R4 full loop word
      '{1'b1, 3'd4, 8'd16,  16'h0001, 1'b0, 16'h0000, 1'b1},  // R5 SHL 16
      '{1'b1, 3'd4, 8'd200, 16'h0001, 1'b0, 16'h0000, 1'b0},  // R5 clamp
      '{1'b0, 3'd5, 8'd8,   16'h0080, 1'b0, 16'h0000, 1'b1},  // R5 SHR byte
      '{1'b1, 3'd7, 8'd255, 16'h8000, 1'b0, 16'hFFFF, 1'b1},  // R5 SAR sign fill
      '{1'b0, 3'd7, 8'd17,  16'h0040, 1'b0, 16'h0000, 1'b0},  // R5 SAR positive
      '{1'b0, 3'd6, 8'd1,   16'h0041, 1'b0, 16'h0082, 1'b0},  // R2 alias code 6
      '{1'b1, 3'd5, 8'd1,   16'h8001, 1'b0, 16'h4000, 1'b1},  // R2 SHR word
      '{1'b0, 3'd3, 8'd1,   16'h0001, 1'b1, 16'h0080, 1'b1}   // R4 RCR byte
   };

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // flags packed as {cf, of, sf, zf, pf}
   task automatic apply(logic wide, logic [2:0] op, logic sel, logic [7:0] imm,
                        logic [7:0] creg, logic mem, logic [15:0] data, logic [4:0] fl);
      @(negedge clk);
      in_wide = wide; in_op = op; in_imm_sel = sel; in_imm = imm; in_creg = creg;
      in_mem = mem; in_data = data;
      {in_cf, in_of, in_sf, in_zf, in_pf} = fl;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [4:0] flags_now();
      return {out_cf, out_of, out_sf, out_zf, out_pf};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 result", out_result, 16'h0);
      check("R1 flags", 16'(flags_now()), 16'h0);
      check("R1 cycles", 16'(out_cycles), 16'h0);
      check("R1 valid", 16'(out_valid), 16'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].wide, VECS[i].op, 1'b1, VECS[i].cnt, ~VECS[i].cnt, 1'b0,
               VECS[i].data, {VECS[i].cin, 4'b0000});
         check($sformatf("R3/R4/R5 vec %0d result", i), out_result, VECS[i].res);
         check($sformatf("R3/R4/R5 vec %0d cf", i), 16'(out_cf), 16'(VECS[i].cf));
         check("R12 valid pulse", 16'(out_valid), 16'h1);
      end

      // R11 zero count, word ROL, flags all set
      apply(1'b1, 3'd0, 1'b0, 8'd7, 8'd0, 1'b0, 16'hABCD, 5'b11111);
      check("R11 result", out_result, 16'hABCD);
      check("R11 flags", 16'(flags_now()), 16'h1F);
      // R11 zero count, shift, flags clear
      apply(1'b0, 3'd4, 1'b1, 8'd0, 8'd9, 1'b0, 16'h0033, 5'b00000);
      check("R11 shift result", out_result, 16'h0033);
      check("R11 shift flags", 16'(flags_now()), 16'h00);

      // R8 rotate passes SF/ZF/PF: ROL byte 0 by 3, in sf=1 zf=0 pf=0
      apply(1'b0, 3'd0, 1'b1, 8'd3, 8'd0, 1'b0, 16'h0000, 5'b00100);
      check("R8 flags", 16'(flags_now()), 16'b00100);

      // R9 R10 SHL byte 0x40 by 1 -> 0x80, cf0 of1 sf1 zf0 pf0
      apply(1'b0, 3'd4, 1'b1, 8'd1, 8'd0, 1'b0, 16'h0040, 5'b00011);
      check("R9 shl result", out_result, 16'h0080);
      check("R9 R10 shl flags", 16'(flags_now()), 16'b01100);
      // R9 R10 SHR byte 0x02 by 2 -> 0, cf1 of0 sf0 zf1 pf1
      apply(1'b0, 3'd5, 1'b1, 8'd2, 8'd0, 1'b0, 16'h0002, 5'b01100);
      check("R9 shr result", out_result, 16'h0000);
      check("R9 R10 shr flags", 16'(flags_now()), 16'b10011);
      // R10 ROR byte 0x01 by 1 -> 0x80, cf1 of1
      apply(1'b0, 3'd1, 1'b1, 8'd1, 8'd0, 1'b0, 16'h0001, 5'b00000);
      check("R10 ror result", out_result, 16'h0080);
      check("R10 ror cf of", 16'({out_cf, out_of}), 16'b11);

      // R6 count source
      apply(1'b0, 3'd4, 1'b1, 8'd1, 8'd5, 1'b0, 16'h0001, 5'b00000);
      check("R6 immediate", out_result, 16'h0002);
      apply(1'b0, 3'd4, 1'b0, 8'd1, 8'd5, 1'b0, 16'h0001, 5'b00000);
      check("R6 count register", out_result, 16'h0020);

      // R7 cost
      apply(1'b1, 3'd4, 1'b1, 8'd200, 8'd0, 1'b0, 16'h0001, 5'b00000);
      check("R7 reg cost", 16'(out_cycles), 16'd205);
      apply(1'b1, 3'd4, 1'b0, 8'd0, 8'd3, 1'b1, 16'h0001, 5'b00000);
      check("R7 mem cost", 16'(out_cycles), 16'd11);
      apply(1'b1, 3'd0, 1'b1, 8'd0, 8'd0, 1'b1, 16'h0001, 5'b00000);
      check("R7 mem zero cost", 16'(out_cycles), 16'd8);

      // R12 hold: change inputs without a strobe
      apply(1'b1, 3'd1, 1'b1, 8'd4, 8'd0, 1'b0, 16'h0001, 5'b00000);
      @(negedge clk);
      in_data = 16'hFFFF; in_op = 3'd4; in_imm = 8'd1; in_mem = 1'b1;
      repeat (2) @(negedge clk);
      check("R12 held result", out_result, 16'h1000);
      check("R12 held cycles", 16'(out_cycles), 16'd9);
      check("R12 valid low", 16'(out_valid), 16'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule